// File: doc/BRIEF.md
# Command-Word MDIO Management Master

This block drives Clause 22 management frames towards PHY devices. A host writes one 32-bit command word. The word holds two request flags (write and read), a 5-bit PHY address, a 5-bit register address, a bus-select flag and, for writes, 16 bits of payload. When a request flag rises, the block serialises a complete frame on the selected MDC/MDIO pin pair. After a read frame, the 16 captured bits appear on a separate read-data output.

A programmable divider derives the management clock from the system clock. MDC is high for `mdc_half_div` system cycles and low for the same number. A divide value of 0 behaves as 1. With a 100 MHz system clock and a value of 20, MDC runs at 2.5 MHz, and a full frame takes 25.6 µs, which is inside the 50 µs budget the host allows. Two pin pairs are available, one internal and one external. Only the pair chosen by the command toggles, and the other stays parked.

The intended host sequence has two writes. The host first writes a word with both request flags clear. It then writes the real command. A command written while a frame is in flight is dropped entirely, and its flags are not remembered.

Top module: `mdio_cmd_master`

## Requirements
- R1: A write frame starts only when bit 31 of an accepted command is 1 and the bit 31 of the previously accepted command was 0. Rewriting the same command with no zero word in between starts nothing. If bits 31 and 30 both rise in the same command, a write frame is sent.
- R2: A read frame starts when bit 30 rises in the same way and bit 31 does not rise.
- R3: Every frame is sent MSB first, one bit per MDC period, and the data only changes while MDC is low. The bit order is:
  - 32 ones (preamble);
  - start code 01;
  - opcode 01 for a write or 10 for a read;
  - the PHY address from command bits 29:25;
  - the register address from command bits 24:20.
- R4: A write frame continues with turnaround 10 and then command bits 15:0. The master drives MDIO for all 64 bits.
- R5: A read frame releases MDIO (output enable 0) for the two turnaround bits and the 16 data bits. Each data bit is sampled on the rising MDC edge. `rd_data` shows the 16 bits, first bit at bit 15, in the same cycle that `busy` falls. The payload bits 15:0 of a read command are ignored.
- R6: Command bit 16 set selects the external pin pair, and clear selects the internal pair. During the frame, the unselected pair keeps MDC at 0 and its output enable at 0.
- R7: MDC idles low. Each MDC phase lasts `mdc_half_div` system cycles, with 0 treated as 1. `busy` stays high for exactly 128 × phase cycles per frame.
- R8: `busy` is 1 from the cycle after the starting write until the frame ends. A command written while busy has no effect: no new frame starts afterwards, and its flags do not count as the previous command.
- R9: After reset, both MDC outputs, both output enables, `busy` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_half_div | input | DIVW | System cycles per MDC phase (0 acts as 1) |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Last read result |
| int_mdc | output | 1 | Internal bus management clock |
| int_mdio_o | output | 1 | Internal bus data out |
| int_mdio_oe | output | 1 | Internal bus data output enable |
| int_mdio_i | input | 1 | Internal bus data in |
| ext_mdc | output | 1 | External bus management clock |
| ext_mdio_o | output | 1 | External bus data out |
| ext_mdio_oe | output | 1 | External bus data output enable |
| ext_mdio_i | input | 1 | External bus data in |

## Verification
The bench builds the block with a 4-bit divide field and drives phase lengths of 1, 2 and 3 cycles, so each frame finishes in a few hundred cycles. This short frame makes it possible to send a write to every one of the 32 PHY addresses, each with a distinct register address and payload, while alternating buses and phase lengths. A dozen reads with different return patterns follow. The short frames also leave room for the edge-detection, both-flags and write-while-busy sequences, each checked bit by bit against frames the bench assembles from the command fields.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int CMD_WR_BIT  = 31;
  localparam int CMD_RD_BIT  = 30;
  localparam int CMD_PHY_LSB = 25;
  localparam int CMD_REG_LSB = 20;
  localparam int CMD_EXT_BIT = 16;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int PRE_LEN     = 32;
  localparam int FRAME_LEN   = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W       = $clog2(FRAME_LEN);
  localparam int TA_POS      = FRAME_LEN - DATA_W - 2;
  localparam int DATA_POS    = FRAME_LEN - DATA_W;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic              ext;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
    mdio_cmd_t c;
    c.wr    = w[CMD_WR_BIT];
    c.rd    = w[CMD_RD_BIT];
    c.phy   = w[CMD_PHY_LSB +: ADDR_W];
    c.regad = w[CMD_REG_LSB +: ADDR_W];
    c.ext   = w[CMD_EXT_BIT];
    c.wdata = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic is_rd, input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad, input logic [DATA_W-1:0] wdata);
    logic [1:0] op, ta;
    logic [DATA_W-1:0] pay;
    op  = is_rd ? 2'b10 : 2'b01;
    ta  = is_rd ? 2'b11 : 2'b10;
    pay = is_rd ? {DATA_W{1'b1}} : wdata;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad, ta, pay};
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] half_div,
  output logic            mdc,
  output logic            rise_tick,
  output logic            fall_tick
);
  logic [DIVW-1:0] cnt_q;
  logic            mdc_q;
  logic [DIVW-1:0] lim;
  logic            term;

  assign lim  = (half_div == '0) ? '0 : half_div - 1'b1;
  assign term = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term && !mdc_q;
  assign fall_tick = term && mdc_q;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdi,
  output logic              busy,
  output logic              mdo,
  output logic              mdo_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, rd_q;
  logic [DATA_W-1:0]    cap_q, rdat_q;
  logic                 last_bit, in_data, released;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign in_data  = (idx_q >= IDX_W'(DATA_POS));
  assign released = rd_q && (idx_q >= IDX_W'(TA_POS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
      rdat_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        rd_q   <= start_rd;
        idx_q  <= '0;
        sh_q   <= build_frame(start_rd, start_phy, start_reg, start_wdata);
      end
    end else begin
      if (rise_tick && rd_q && in_data)
        cap_q <= {cap_q[DATA_W-2:0], mdi};
      if (fall_tick) begin
        sh_q  <= sh_q << 1;
        idx_q <= idx_q + 1'b1;
        if (last_bit) begin
          busy_q <= 1'b0;
          if (rd_q) rdat_q <= cap_q;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdo     = sh_q[FRAME_LEN-1];
  assign mdo_oe  = busy_q && !released;
  assign rd_data = rdat_q;

  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (idx_q < IDX_W'(PRE_LEN)) |-> mdo); // R3
  AST_TA_WRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !rd_q && (idx_q == IDX_W'(TA_POS)) |-> mdo && mdo_oe); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last_bit |=> busy_q); // R8
endmodule

// File: rtl/mdio_bus_steer.sv
module mdio_bus_steer (
  input  logic sel_ext,
  input  logic mdc,
  input  logic mdo,
  input  logic mdo_oe,
  output logic mdi,
  output logic int_mdc,
  output logic int_mdio_o,
  output logic int_mdio_oe,
  input  logic int_mdio_i,
  output logic ext_mdc,
  output logic ext_mdio_o,
  output logic ext_mdio_oe,
  input  logic ext_mdio_i
);
  assign int_mdc     = mdc && !sel_ext;
  assign int_mdio_oe = mdo_oe && !sel_ext;
  assign int_mdio_o  = mdo && !sel_ext;
  assign ext_mdc     = mdc && sel_ext;
  assign ext_mdio_oe = mdo_oe && sel_ext;
  assign ext_mdio_o  = mdo && sel_ext;
  assign mdi         = sel_ext ? ext_mdio_i : int_mdio_i;
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIVW-1:0]   mdc_half_div,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              int_mdc,
  output logic              int_mdio_o,
  output logic              int_mdio_oe,
  input  logic              int_mdio_i,
  output logic              ext_mdc,
  output logic              ext_mdio_o,
  output logic              ext_mdio_oe,
  input  logic              ext_mdio_i
);
  mdio_cmd_t cmd;
  logic prev_wr_q, prev_rd_q, ext_q;
  logic eng_busy, accept, wr_rise, rd_rise, launch;
  logic core_mdc, rise_tick, fall_tick, core_mdo, core_oe, core_mdi;

  assign cmd     = decode_cmd(cmd_wdata);
  assign accept  = cmd_we && !eng_busy;
  assign wr_rise = cmd.wr && !prev_wr_q;
  assign rd_rise = cmd.rd && !prev_rd_q;
  assign launch  = accept && (wr_rise || rd_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr_q <= 1'b0;
      prev_rd_q <= 1'b0;
      ext_q     <= 1'b0;
    end else if (accept) begin
      prev_wr_q <= cmd.wr;
      prev_rd_q <= cmd.rd;
      if (launch) ext_q <= cmd.ext;
    end
  end

  mdc_divider #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .half_div(mdc_half_div),
    .mdc(core_mdc), .rise_tick(rise_tick), .fall_tick(fall_tick));

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(launch), .start_rd(!wr_rise),
    .start_phy(cmd.phy), .start_reg(cmd.regad), .start_wdata(cmd.wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdi(core_mdi),
    .busy(eng_busy), .mdo(core_mdo), .mdo_oe(core_oe), .rd_data(rd_data));

  mdio_bus_steer u_steer (
    .sel_ext(ext_q), .mdc(core_mdc), .mdo(core_mdo), .mdo_oe(core_oe),
    .mdi(core_mdi),
    .int_mdc(int_mdc), .int_mdio_o(int_mdio_o), .int_mdio_oe(int_mdio_oe),
    .int_mdio_i(int_mdio_i),
    .ext_mdc(ext_mdc), .ext_mdio_o(ext_mdio_o), .ext_mdio_oe(ext_mdio_oe),
    .ext_mdio_i(ext_mdio_i));

  assign busy = eng_busy;

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !int_mdc && !ext_mdc && !int_mdio_oe && !ext_mdio_oe); // R9
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_mdc && ext_mdc) && !(int_mdio_oe && ext_mdio_oe)); // R6
  AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_mdc && $past(core_mdc) |-> $stable(core_mdo)); // R3
  AST_MDC_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> !core_mdc); // R7
  AST_BUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && $past(eng_busy) |-> $stable(ext_q)); // R8
endmodule

// File: tb/mdio_cmd_master_bench.sv
module mdio_cmd_master_bench;
  localparam int DIVW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [DIVW-1:0] half = 4'd1;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic            phy_bit = 1'b1;
  logic            busy;
  logic [15:0]     rd_data;
  logic int_mdc, int_o, int_oe, ext_mdc, ext_o, ext_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mdio_cmd_master #(.DIVW(DIVW)) u_mdio_cmd_master (
    .clk(clk), .rst_n(rst_n), .mdc_half_div(half), .cmd_we(we), .cmd_wdata(wdata),
    .busy(busy), .rd_data(rd_data),
    .int_mdc(int_mdc), .int_mdio_o(int_o), .int_mdio_oe(int_oe), .int_mdio_i(phy_bit),
    .ext_mdc(ext_mdc), .ext_mdio_o(ext_o), .ext_mdio_oe(ext_oe), .ext_mdio_i(phy_bit));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] c);
    @(negedge clk);
    we = 1'b1;
    wdata = c;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] c);
    logic wr;
    wr = c[31];
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), c[29:25], c[24:20],
            (wr ? 2'b10 : 2'b11), (wr ? c[15:0] : 16'hFFFF)};
  endfunction

  task automatic run_frame(input logic [31:0] c, input int h, input logic [15:0] pdata,
                           output logic [63:0] bits, output logic [63:0] oes,
                           output int cyc, output int quiet);
    int rises, falls;
    logic pm, sm, so, soe, seen;
    half = DIVW'(h);
    write_cmd(32'h0);
    write_cmd(c);
    bits = '0; oes = '0; cyc = 0; quiet = 0;
    rises = 0; falls = 0; pm = 1'b0; seen = 1'b0; phy_bit = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      sm  = c[16] ? ext_mdc : int_mdc;
      so  = c[16] ? ext_o   : int_o;
      soe = c[16] ? ext_oe  : int_oe;
      if (c[16] ? (int_mdc || int_oe) : (ext_mdc || ext_oe)) quiet++;
      if (busy) begin cyc++; seen = 1'b1; end
      if (!pm && sm && rises < 64) begin
        bits[63-rises] = so;
        oes[63-rises]  = soe;
        rises++;
      end
      if (pm && !sm) begin
        falls++;
        phy_bit = (falls >= 48 && falls < 64) ? pdata[15-(falls-48)] : 1'b1;
      end
      pm = sm;
      if (seen && !busy) break;
      @(negedge clk);
    end
  endtask

  task automatic watch_idle(input int n, output int act);
    act = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (busy || int_mdc || ext_mdc || int_oe || ext_oe) act++;
    end
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 150000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cnt, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] bits, oes, ef;
    logic [31:0] c;
    logic [15:0] pd;
    int cyc, quiet, act, h;

    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !int_mdc && !ext_mdc && !int_oe && !ext_oe, "R9", "pins in reset",
          {busy, int_mdc, ext_mdc, int_oe, ext_oe}, 0);
    check(rd_data == 16'h0, "R9", "rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !int_mdc && !ext_mdc, "R9", "idle after reset", {busy, int_mdc, ext_mdc}, 0);

    // R3 R4 R6 R7: write sweep over all PHY addresses
    for (int p = 0; p < 32; p++) begin
      h = 1 + p % 3;
      c = (32'h1 << 31) | (32'(p) << 25) | (32'(31 - p) << 20) | (32'(p % 2) << 16)
          | 32'((p * 16'h0811) ^ 16'hA5C3);
      run_frame(c, h, 16'h0, bits, oes, cyc, quiet);
      ef = exp_frame(c);
      check(bits == ef, "R3/R4", "write frame bits", bits, ef);
      check(oes == {64{1'b1}}, "R4", "write drive enable", oes, {64{1'b1}});
      check(cyc == 128 * h, "R7", "busy length", cyc, 128 * h);
      check(quiet == 0, "R6", "unselected bus quiet", quiet, 0);
    end

    // R2 R5 R6: reads with varied return patterns
    for (int p = 0; p < 12; p++) begin
      h = 1 + p % 2;
      c = (32'h1 << 30) | (32'((p * 3) % 32) << 25) | (32'((p * 7) % 32) << 20)
          | (32'((p >> 1) & 1) << 16) | 32'h1234;
      pd = 16'h8001 ^ 16'(p * 16'h1357);
      run_frame(c, h, pd, bits, oes, cyc, quiet);
      ef = exp_frame(c);
      check((bits[63:18] == ef[63:18]), "R2/R3", "read header bits", bits[63:18], ef[63:18]);
      check(oes == {{46{1'b1}}, 18'h0}, "R5", "read release", oes, {{46{1'b1}}, 18'h0});
      check(rd_data == pd, "R5", "read data", rd_data, pd);
      check(quiet == 0, "R6", "unselected bus quiet on read", quiet, 0);
      check(cyc == 128 * h, "R8", "busy over read", cyc, 128 * h);
    end

    // R1: same write again without zero word starts nothing
    half = 4'd1;
    c = (32'h1 << 31) | (32'd5 << 25) | (32'd9 << 20) | 32'hBEEF;
    run_frame(c, 1, 16'h0, bits, oes, cyc, quiet);
    write_cmd(c);
    watch_idle(60, act);
    check(act == 0, "R1", "repeat write without zero", act, 0);

    // R1: both flags rise together -> write frame
    c = (32'h3 << 30) | (32'd17 << 25) | (32'd3 << 20) | 32'h0F0F;
    run_frame(c, 2, 16'h0, bits, oes, cyc, quiet);
    ef = exp_frame(c);
    check(bits == ef, "R1", "both flags give write", bits, ef);

    // R8: command while busy is ignored and not remembered
    half = 4'd1;
    write_cmd(32'h0);
    write_cmd((32'h1 << 30) | (32'd2 << 25));
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R8", "busy mid frame", busy, 1);
    write_cmd((32'h1 << 31) | (32'd4 << 25) | 32'h1111);
    for (int k = 0; k < 400 && busy; k++) @(negedge clk);
    watch_idle(60, act);
    check(act == 0, "R8", "no frame after busy write", act, 0);
    c = (32'h1 << 31) | (32'd6 << 25) | (32'd7 << 20) | 32'h5A5A;
    run_frame(c, 1, 16'h0, bits, oes, cyc, quiet);
    ef = exp_frame(c);
    check(bits == ef, "R8", "later write after ignored one", bits, ef);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule